// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns the oscillator clock of a small 8-bit controller core into the strobe pattern of a multiplexed external memory bus. A 12-clock machine cycle is split into two 6-clock fetch slots. Each slot opens with a 2-clock address-latch pulse, during which the low byte of the address sits on the shared low port. It then lowers the program-store strobe for the last three clocks, and the instruction byte is read back on that same port. Whether a slot goes to the external bus depends on the external-access select pin and on the program counter value.

The core can also ask for one external data read or write. It gives either a 16-bit pointer or an 8-bit register-indirect address. The request is taken only at a machine-cycle boundary, and the whole next machine cycle is then a data cycle. That cycle has a single address-latch pulse and no program-store pulses, and the read or write strobe is low for six clocks. A busy flag covers exactly that cycle. Fetched instruction bytes and read data go back to the core with one-clock valid pulses.

Top module: `xbus_sequencer`

## Requirements
- R1: While reset (active-low) is held, the address-latch strobe is low, the program-store, read and write strobes (all active-low) are high, the low port is not driven, and busy, the instruction-valid output and the read-valid output are low.
- R2: In fetch cycles the address-latch strobe is high for 2 clocks at the start of every 6-clock slot, which gives 4 high clocks per 12-clock machine cycle.
- R3: A slot fetches externally when the select pin is 0, or when the pin is 1 and the program counter is above 0x0FFF. The program-store strobe is then low on slot clocks 3, 4 and 5, and never while the address-latch strobe is high.
- R4: A slot that fetches internally keeps the program-store strobe high, leaves the low port undriven, returns no instruction, and shows the high-byte latch input on the high port.
- R5: In an external fetch, the low port drives PC[7:0] and the high port drives PC[15:8] while the address-latch strobe is high. The byte on the low-port input at slot clock 5 is returned with instruction-valid high on clock 0 of the next slot.
- R6: A data request (write wins if both are raised) is accepted only at the last clock of a fetch machine cycle. Busy then rises together with the address-latch strobe and stays high for exactly 12 clocks.
- R7: In a data cycle, counting clocks 0 to 11 from the rise of busy, the address-latch strobe is high on clocks 0 and 1 only, the program-store strobe stays high, and the read or write strobe is low on clocks 3 to 8. Read and write are never low together.
- R8: In a data cycle the low port carries address[7:0] on clocks 0 and 1. The high port carries address[15:8] in pointer mode and the high-byte latch input in register-indirect mode, for the whole cycle.
- R9: In a read cycle the low port is not driven after clock 1. The low-port input at clock 8 is returned with read-valid high on clock 9.
- R10: In a write cycle the low port drives the write byte from clock 2 through clock 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcAddr | input | 16 | Fetch address from the program counter |
| extSel | input | 1 | External-access select; 0 forces every fetch to the external bus |
| reqRd | input | 1 | Data read request, held until busy is seen |
| reqWr | input | 1 | Data write request, held until busy is seen |
| usePtr | input | 1 | 1: 16-bit pointer address; 0: 8-bit register-indirect address |
| dataAddr | input | 16 | Data address; only bits 7..0 are used in register-indirect mode |
| wrData | input | 8 | Write byte |
| hiLatch | input | 8 | Current contents of the high-byte port latch |
| lowPortIn | input | 8 | Low port input from the bus |
| aleOut | output | 1 | Address-latch strobe, active high |
| psenN | output | 1 | Program-store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| lowPortOut | output | 8 | Low port output value (address or write data) |
| lowPortOe | output | 1 | Low port output enable |
| highPortOut | output | 8 | High address port |
| instrByte | output | 8 | Fetched instruction byte |
| instrValid | output | 1 | One-clock pulse marking a new instrByte |
| rdByte | output | 8 | Read data byte |
| rdValid | output | 1 | One-clock pulse marking a new rdByte |
| busy | output | 1 | High for the whole accepted data cycle |

## Verification
Every strobe is a decode of registered phase state, so it changes one clock after the edge that moves the phase. Instruction and read bytes are registered once more and appear exactly one clock after their sampling clock. The bench samples on falling edges and keeps its position by anchoring on a rising address-latch pulse for fetch slots, or on the first clock with busy high for data cycles. From that anchor it counts falling edges and compares each strobe, port value and valid pulse against the expected phase table for that clock. The external memory model latches the address seen during the latch pulse and returns a computed byte, so the returned data shows up at the predicted clock (slot clock 0 for fetches, data clock 9 for reads).

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef struct packed {
    logic ale;
    logic psenWin;
    logic fetchCapture;
    logic loadFetch;
    logic dataMode;
    logic accept;
    logic rdOn;
    logic wrOn;
    logic wrDrive;
    logic rdCapture;
  } busStrobe_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int ALE_LEN   = 2,
  parameter int PULSE_LEN = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqRd,
  input  logic       reqWr,
  output busStrobe_t stb,
  output logic       busy
);
  localparam int PH_W = $clog2(CYCLE_LEN);
  localparam logic [PH_W-1:0] LAST_PH    = PH_W'(CYCLE_LEN - 1);
  localparam logic [PH_W-1:0] SLOT_PH    = PH_W'(CYCLE_LEN / 2);
  localparam logic [PH_W-1:0] SLOT_LAST  = PH_W'(CYCLE_LEN / 2 - 1);
  localparam logic [PH_W-1:0] ALE_END    = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] PSEN_FIRST = PH_W'(CYCLE_LEN / 4);
  localparam logic [PH_W-1:0] STB_FIRST  = PH_W'(ALE_LEN + 1);
  localparam logic [PH_W-1:0] STB_LAST   = PH_W'(ALE_LEN + PULSE_LEN);
  localparam logic [PH_W-1:0] DRV_FIRST  = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] DRV_LAST   = PH_W'(ALE_LEN + PULSE_LEN + 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] slotPos;
  logic live;
  logic dataCycle;
  logic isWrite;
  logic inFetch;
  logic inData;
  logic pulseWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      live      <= 1'b0;
      phase     <= '0;
      dataCycle <= 1'b0;
      isWrite   <= 1'b0;
    end else if (!live) begin
      live <= 1'b1;
    end else begin
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
      if (phase == LAST_PH) begin
        if (dataCycle) begin
          dataCycle <= 1'b0;
        end else if (reqRd || reqWr) begin
          dataCycle <= 1'b1;
          isWrite   <= reqWr;
        end
      end
    end
  end

  always_comb begin
    slotPos  = (phase >= SLOT_PH) ? phase - SLOT_PH : phase;
    inFetch  = live && !dataCycle;
    inData   = live && dataCycle;
    pulseWin = inData && (phase >= STB_FIRST) && (phase <= STB_LAST);
    stb.ale          = inFetch ? (slotPos < ALE_END) : (inData && (phase < ALE_END));
    stb.psenWin      = inFetch && (slotPos >= PSEN_FIRST);
    stb.fetchCapture = inFetch && (slotPos == SLOT_LAST);
    stb.loadFetch    = !live || (slotPos == SLOT_LAST);
    stb.dataMode     = inData;
    stb.accept       = inFetch && (phase == LAST_PH) && (reqRd || reqWr);
    stb.rdOn         = pulseWin && !isWrite;
    stb.wrOn         = pulseWin && isWrite;
    stb.wrDrive      = inData && isWrite && (phase >= DRV_FIRST) && (phase <= DRV_LAST);
    stb.rdCapture    = inData && !isWrite && (phase == STB_LAST);
  end

  assign busy = dataCycle;

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataCycle) |-> (phase == '0));
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h0FFF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               stb,
  input  logic [ADDR_W-1:0]        pcAddr,
  input  logic                     extSel,
  input  logic                     usePtr,
  input  logic [ADDR_W-1:0]        dataAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-DATA_W-1:0] hiLatch,
  input  logic [DATA_W-1:0]        lowPortIn,
  output logic                     aleOut,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        lowPortOut,
  output logic                     lowPortOe,
  output logic [ADDR_W-DATA_W-1:0] highPortOut,
  output logic [DATA_W-1:0]        instrByte,
  output logic                     instrValid,
  output logic [DATA_W-1:0]        rdByte,
  output logic                     rdValid
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] fetchAddr;
  logic              extFetch;
  logic              extNext;
  logic [ADDR_W-1:0] dAddr;
  logic              dUsePtr;
  logic [DATA_W-1:0] dWrData;
  logic [HI_W-1:0]   dataHi;

  assign extNext = !extSel || (pcAddr > INT_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr  <= '0;
      extFetch   <= 1'b0;
      dAddr      <= '0;
      dUsePtr    <= 1'b0;
      dWrData    <= '0;
      instrByte  <= '0;
      instrValid <= 1'b0;
      rdByte     <= '0;
      rdValid    <= 1'b0;
    end else begin
      if (stb.loadFetch) begin
        fetchAddr <= pcAddr;
        extFetch  <= extNext;
      end
      if (stb.accept) begin
        dAddr   <= dataAddr;
        dUsePtr <= usePtr;
        dWrData <= wrData;
      end
      instrValid <= stb.fetchCapture && extFetch;
      if (stb.fetchCapture && extFetch) instrByte <= lowPortIn;
      rdValid <= stb.rdCapture;
      if (stb.rdCapture) rdByte <= lowPortIn;
    end
  end

  always_comb begin
    dataHi      = dUsePtr ? dAddr[ADDR_W-1:DATA_W] : hiLatch;
    aleOut      = stb.ale;
    psenN       = !(stb.psenWin && extFetch);
    rdN         = !stb.rdOn;
    wrN         = !stb.wrOn;
    lowPortOe   = (stb.ale && (stb.dataMode || extFetch)) || stb.wrDrive;
    lowPortOut  = stb.wrDrive ? dWrData :
                  (stb.dataMode ? dAddr[DATA_W-1:0] : fetchAddr[DATA_W-1:0]);
    highPortOut = stb.dataMode ? dataHi :
                  (extFetch ? fetchAddr[ADDR_W-1:DATA_W] : hiLatch);
  end

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  // R7
  data_no_psen_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataMode |-> psenN);
  // R3
  ale_psen_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> psenN);
  // R9
  rd_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !lowPortOe);
  // R10
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> lowPortOe);
  // R5
  instr_after_psen_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |-> $past(!psenN));
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CYCLE_LEN = 12,
  parameter int ALE_LEN   = 2,
  parameter int PULSE_LEN = 6,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h0FFF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        pcAddr,
  input  logic                     extSel,
  input  logic                     reqRd,
  input  logic                     reqWr,
  input  logic                     usePtr,
  input  logic [ADDR_W-1:0]        dataAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-DATA_W-1:0] hiLatch,
  input  logic [DATA_W-1:0]        lowPortIn,
  output logic                     aleOut,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        lowPortOut,
  output logic                     lowPortOe,
  output logic [ADDR_W-DATA_W-1:0] highPortOut,
  output logic [DATA_W-1:0]        instrByte,
  output logic                     instrValid,
  output logic [DATA_W-1:0]        rdByte,
  output logic                     rdValid,
  output logic                     busy
);
  xbus_pkg::busStrobe_t stb;

  xbus_ctrl #(
    .CYCLE_LEN(CYCLE_LEN), .ALE_LEN(ALE_LEN), .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqRd(reqRd), .reqWr(reqWr),
    .stb(stb), .busy(busy)
  );

  xbus_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_TOP(INT_TOP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pcAddr(pcAddr), .extSel(extSel),
    .usePtr(usePtr), .dataAddr(dataAddr), .wrData(wrData), .hiLatch(hiLatch),
    .lowPortIn(lowPortIn), .aleOut(aleOut), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .lowPortOut(lowPortOut), .lowPortOe(lowPortOe), .highPortOut(highPortOut),
    .instrByte(instrByte), .instrValid(instrValid), .rdByte(rdByte),
    .rdValid(rdValid)
  );
endmodule

// File: tb/xbus_sequencer_bench.sv
`timescale 1ns/1ps
module xbus_sequencer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] pcAddr = '0;
  logic extSel = 1'b0;
  logic reqRd = 1'b0;
  logic reqWr = 1'b0;
  logic usePtr = 1'b0;
  logic [15:0] dataAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] hiLatch = 8'h5C;
  logic [7:0] lowPortIn;
  logic aleOut, psenN, rdN, wrN, lowPortOe, instrValid, rdValid, busy;
  logic [7:0] lowPortOut, highPortOut, instrByte, rdByte;
  logic [15:0] latched = '0;
  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  xbus_sequencer u_xbus_sequencer (
    .clk(clk), .rstN(rstN), .pcAddr(pcAddr), .extSel(extSel), .reqRd(reqRd),
    .reqWr(reqWr), .usePtr(usePtr), .dataAddr(dataAddr), .wrData(wrData),
    .hiLatch(hiLatch), .lowPortIn(lowPortIn), .aleOut(aleOut), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .lowPortOut(lowPortOut), .lowPortOe(lowPortOe),
    .highPortOut(highPortOut), .instrByte(instrByte), .instrValid(instrValid),
    .rdByte(rdByte), .rdValid(rdValid), .busy(busy)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // external memory model: latch address while strobe is high
  always @(negedge clk) if (aleOut && lowPortOe) latched <= {highPortOut, lowPortOut};
  assign lowPortIn = memf(latched);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  task automatic checkReset();
    repeat (4) @(negedge clk);
    chk(aleOut == 1'b0, "R1", "ale", aleOut, 0);
    chk(psenN == 1'b1 && rdN == 1'b1 && wrN == 1'b1, "R1", "strobes",
        {psenN, rdN, wrN}, 3'b111);
    chk(lowPortOe == 1'b0, "R1", "oe", lowPortOe, 0);
    chk(busy == 1'b0 && instrValid == 1'b0 && rdValid == 1'b0, "R1", "flags",
        {busy, instrValid, rdValid}, 0);
  endtask

  task automatic waitSlotStart();
    logic prev = aleOut;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (aleOut && !prev) return;
      prev = aleOut;
    end
    chk(1'b0, "R2", "slot start not found", 0, 1);
  endtask

  task automatic testFetch(input logic ea, input logic [15:0] pc, input bit ext);
    extSel = ea;
    pcAddr = pc;
    repeat (14) @(negedge clk);
    waitSlotStart();
    for (int k = 0; k < 12; k++) begin
      int s;
      if (k > 0) @(negedge clk);
      s = k % 6;
      chk(aleOut == (s < 2), "R2", "ale", aleOut, s < 2);
      chk(psenN == !(ext && s >= 3), ext ? "R3" : "R4", "psenN", psenN, !(ext && s >= 3));
      chk(lowPortOe == (ext && s < 2), ext ? "R5" : "R4", "oe", lowPortOe, ext && s < 2);
      chk(instrValid == (ext && s == 0), ext ? "R5" : "R4", "instrValid",
          instrValid, ext && s == 0);
      if (ext && s < 2)
        chk({highPortOut, lowPortOut} == pc, "R5", "address", {highPortOut, lowPortOut}, pc);
      if (!ext)
        chk(highPortOut == hiLatch, "R4", "high port", highPortOut, hiLatch);
      if (instrValid)
        chk(instrByte == memf(pc), "R5", "instrByte", instrByte, memf(pc));
    end
  endtask

  task automatic testData(input bit isWr, input logic ptr, input logic [15:0] addr,
                          input logic [7:0] wdat, input logic [7:0] latch);
    logic [7:0] hiExp;
    bit found = 0;
    hiLatch = latch;
    usePtr = ptr;
    dataAddr = addr;
    wrData = wdat;
    reqWr = isWr;
    reqRd = !isWr;
    for (int i = 0; i < 30 && !found; i++) begin
      @(negedge clk);
      found = busy;
    end
    chk(found, "R6", "busy seen", found, 1);
    reqRd = 1'b0;
    reqWr = 1'b0;
    hiExp = ptr ? addr[15:8] : latch;
    for (int p = 0; p < 12; p++) begin
      bit pulse;
      if (p > 0) @(negedge clk);
      pulse = (p >= 3 && p <= 8);
      chk(busy == 1'b1, "R6", "busy held", busy, 1);
      chk(aleOut == (p < 2), "R7", "ale", aleOut, p < 2);
      chk(psenN == 1'b1, "R7", "psenN", psenN, 1);
      chk(rdN == !(pulse && !isWr), "R7", "rdN", rdN, !(pulse && !isWr));
      chk(wrN == !(pulse && isWr), "R7", "wrN", wrN, !(pulse && isWr));
      chk(highPortOut == hiExp, "R8", "high port", highPortOut, hiExp);
      if (p < 2)
        chk(lowPortOe && lowPortOut == addr[7:0], "R8", "low addr",
            lowPortOut, addr[7:0]);
      if (isWr) begin
        chk(lowPortOe == (p <= 9), "R10", "oe", lowPortOe, p <= 9);
        if (p >= 2 && p <= 9)
          chk(lowPortOut == wdat, "R10", "write byte", lowPortOut, wdat);
      end else begin
        chk(lowPortOe == (p < 2), "R9", "oe", lowPortOe, p < 2);
        chk(rdValid == (p == 9), "R9", "rdValid", rdValid, p == 9);
        if (p == 9)
          chk(rdByte == memf({hiExp, addr[7:0]}), "R9", "rdByte", rdByte,
              memf({hiExp, addr[7:0]}));
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, "R6", "busy length", busy, 0);
  endtask

  task automatic testAccept();
    int n = 0;
    waitSlotStart();
    repeat (2) @(negedge clk);
    usePtr = 1'b1;
    dataAddr = 16'h2233;
    reqRd = 1'b1;
    while (n < 30) begin
      @(negedge clk);
      n++;
      if (busy) break;
    end
    chk(n == 4 || n == 10, "R6", "clocks to accept", n, 10);
    chk(aleOut == 1'b1, "R6", "ale at busy rise", aleOut, 1);
    reqRd = 1'b0;
    repeat (13) @(negedge clk);
  endtask

  initial begin
    checkReset();
    @(negedge clk);
    rstN = 1'b1;
    testFetch(1'b0, 16'h1234, 1'b1);
    testFetch(1'b1, 16'h0800, 1'b0);
    testFetch(1'b1, 16'h0FFF, 1'b0);
    testFetch(1'b1, 16'h1000, 1'b1);
    testFetch(1'b0, 16'h0042, 1'b1);
    extSel = 1'b0;
    pcAddr = 16'h2000;
    testData(1'b1, 1'b1, 16'hBEEF, 8'h3C, 8'h5C);
    testData(1'b0, 1'b0, 16'h0033, 8'h00, 8'h47);
    testData(1'b0, 1'b1, 16'hA5F0, 8'h00, 8'h47);
    testData(1'b1, 1'b0, 16'h0011, 8'h99, 8'h21);
    testAccept();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule